// File: doc/BRIEF.md
# CAN Bit Timing Unit with Diagnostic Loop

The unit turns the system clock into CAN bit timing. A programmable divider makes time quanta. Each bit is then built from one synchronization quantum, a first timing segment of programmable length, and a second timing segment of programmable length. The received line is sampled where the first segment ends. Transmit data is launched where a new bit begins. A one-clock strobe marks each of these points for the protocol logic.

The unit follows the other nodes on the bus. While the bus is idle, a recessive-to-dominant edge restarts the bit; this is a hard sync. Once a frame is under way, an edge outside the synchronization quantum either stretches the first segment or trims the second, within a programmable jump width. This covers propagation delay and clock drift between nodes.

A diagnostic loop setting cuts the node off from the bus. The transmit pin is held recessive, the receive pin is ignored, and the node's own transmitted bit is fed back into the receive path. Each sampled bit is compared with the bit being sent, and a mismatch raises a bit-error pulse.

Top module: `can_bit_timing`

## Requirements
- R1: A time quantum lasts `brp_i`+1 clocks. With no edges on the effective receive line, a bit lasts 1+`tseg1_i`+`tseg2_i` quanta, so `tx_strobe_o` repeats every (`brp_i`+1)*(1+`tseg1_i`+`tseg2_i`) clocks. Legal ranges are `tseg1_i` 1..16, `tseg2_i` 1..8 and `sjw_i` 1..4.
- R2: `tx_strobe_o` pulses for one clock as each bit begins. On that same edge, `tx_bit_i` is captured and held as the transmitted bit for the whole bit. Outside loop mode, `tx_o` shows the transmitted bit (1 = recessive).
- R3: `sample_o` pulses for one clock when the last quantum of the first segment ends. With no resynchronization, that is `tseg2_i` quanta before the next `tx_strobe_o`.
- R4: `rx_i` passes through two synchronizer flops before edge detection and sampling. `rx_bit_o` takes the effective receive value at each sample and holds it between samples. After a hard sync with `brp_i`=0, the sample falls `tseg1_i`+3 clocks after `rx_i` goes low.
- R5: The bus counts as idle after reset and after 11 consecutive recessive samples. It stops being idle at a dominant sample. While idle, a recessive-to-dominant edge makes the current quantum the synchronization quantum. No further resynchronization happens until the next sample.
- R6: An edge in the first segment (not idle, no resync since the last sample) lengthens that segment. The added amount is the smaller of the edge's quantum position in the segment (1-based) and `sjw_i`.
- R7: An edge in the second segment (not idle, no resync since the last sample) cuts that segment to the larger of the edge's quantum position and `tseg2_i`-`sjw_i`.
- R8: With `loop_i`=1, `tx_o` stays 1, `rx_i` has no effect, and the transmitted bit is what gets sampled. `rx_bit_o` therefore equals the transmitted bit and `bit_err_o` stays 0.
- R9: `bit_err_o` pulses together with `sample_o` when the sampled value differs from the transmitted bit.
- R10: In reset, `tx_o`=1, `rx_bit_o`=1, and `sample_o`, `tx_strobe_o` and `bit_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| brp_i | input | 8 | Prescaler; quantum is brp_i+1 clocks |
| tseg1_i | input | 5 | First segment length in quanta (1..16) |
| tseg2_i | input | 4 | Second segment length in quanta (1..8) |
| sjw_i | input | 3 | Resynchronization jump width (1..4) |
| loop_i | input | 1 | Diagnostic loop enable |
| rx_i | input | 1 | Receive pin from transceiver |
| tx_bit_i | input | 1 | Bit to transmit from protocol logic |
| tx_o | output | 1 | Transmit pin to transceiver |
| rx_bit_o | output | 1 | Last sampled bit |
| sample_o | output | 1 | Sample point strobe |
| tx_strobe_o | output | 1 | Bit start strobe |
| bit_err_o | output | 1 | Sampled bit differs from transmitted bit |

## Verification
The bench drives the receive pin from a simulated remote sender whose bit period is deliberately a little longer, and then a little shorter, than the node's own. Edges therefore land in both segments.

Each case and what a wrong design would show:
- **Late edges (slow sender):** a design that stretched without the jump-width clamp, or resynced more than once per sample, would drift its sample strobes against the reference.
- **Early edges (fast sender):** same failure mode, seen as drift in the shortened second segment.
- **Hard sync:** the sample position after a hard sync is pinned to an exact clock count. A missing or extra synchronizer stage, or a hard sync taken while not idle, shifts it.
- **Idle re-entry:** the bench runs 11 recessive bits and then sends a new start edge, so the idle counter is exercised on its way back to hard sync.
- **Loop mode:** the receive pin toggles randomly while loop mode is on. Any leak of the bus into the sampled bit shows up as a wrong `rx_bit_o` or a false `bit_err_o`.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_TS1  = 2'd1,
    SEG_TS2  = 2'd2
  } can_seg_e;
endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int PRESC_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] brp_i,
  output logic               tick_o
);
  logic [PRESC_W-1:0] cnt_q;

  // >= keeps the divider safe when brp_i is lowered mid-count
  assign tick_o = (cnt_q >= brp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/can_bt_rx_front.sv
module can_bt_rx_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic loop_i,
  input  logic tx_q_i,
  output logic rx_eff_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= rx_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
      end
    end
  endgenerate

  // loop: bus ignored, own transmitted bit returned
  assign rx_eff_o = loop_i ? tx_q_i : sync_q[SYNC_STAGES-1];
  assign fall_o   = prev_q & ~rx_eff_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= rx_eff_o;
  end
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int TSEG1_W   = 5,
  parameter int TSEG2_W   = 4,
  parameter int SJW_W     = 3,
  parameter int IDLE_BITS = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               fall_i,
  input  logic               rx_eff_i,
  input  logic [TSEG1_W-1:0] tseg1_i,
  input  logic [TSEG2_W-1:0] tseg2_i,
  input  logic [SJW_W-1:0]   sjw_i,
  output logic               sample_hit_o,
  output logic               bit_end_o
);
  localparam int CNT_W  = TSEG1_W + 1;
  localparam int IDLE_W = $clog2(IDLE_BITS + 1);

  can_seg_e           seg_q;
  logic [CNT_W-1:0]   cnt_q, ext_q, lim2_q;
  logic               used_q, pend_q, idle_q;
  logic [IDLE_W-1:0]  rcnt_q, rcnt_n;
  logic               ev_w, hsync_w, resync_w;
  logic [CNT_W-1:0]   pos1, sjw_x, t1_x, t2_x, ext_n, lim2_n, t2_min;

  always_comb begin
    ev_w     = pend_q | fall_i;
    hsync_w  = tick_i & ev_w & idle_q;
    resync_w = tick_i & ev_w & ~idle_q & ~used_q & (seg_q != SEG_SYNC);
    pos1     = cnt_q + 1'b1;
    sjw_x    = CNT_W'(sjw_i);
    t1_x     = CNT_W'(tseg1_i);
    t2_x     = CNT_W'(tseg2_i);
    ext_n    = ext_q;
    if (resync_w && seg_q == SEG_TS1) ext_n = (pos1 < sjw_x) ? pos1 : sjw_x;
    t2_min   = (t2_x > sjw_x) ? t2_x - sjw_x : '0;
    lim2_n   = lim2_q;
    if (resync_w && seg_q == SEG_TS2) lim2_n = (pos1 > t2_min) ? pos1 : t2_min;
    sample_hit_o = tick_i & ~hsync_w & (seg_q == SEG_TS1) & (pos1 >= t1_x + ext_n);
    bit_end_o    = tick_i & ~hsync_w & (seg_q == SEG_TS2) & (pos1 >= lim2_n);
    rcnt_n   = (rcnt_q == IDLE_W'(IDLE_BITS)) ? rcnt_q : rcnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q  <= SEG_SYNC;
      cnt_q  <= '0;
      ext_q  <= '0;
      lim2_q <= '0;
      used_q <= 1'b0;
      pend_q <= 1'b0;
      idle_q <= 1'b1;
      rcnt_q <= '0;
    end else begin
      if (tick_i)      pend_q <= 1'b0;
      else if (fall_i) pend_q <= 1'b1;

      if (sample_hit_o) begin
        if (!rx_eff_i) begin
          idle_q <= 1'b0;
          rcnt_q <= '0;
        end else begin
          rcnt_q <= rcnt_n;
          if (rcnt_n >= IDLE_W'(IDLE_BITS)) idle_q <= 1'b1;
        end
      end

      if (hsync_w) begin
        seg_q  <= SEG_TS1;
        cnt_q  <= '0;
        ext_q  <= '0;
        used_q <= 1'b1;
      end else if (tick_i) begin
        unique case (seg_q)
          SEG_SYNC: begin
            seg_q <= SEG_TS1;
            cnt_q <= '0;
            ext_q <= '0;
          end
          SEG_TS1: begin
            ext_q <= ext_n;
            if (resync_w) used_q <= 1'b1;
            if (sample_hit_o) begin
              seg_q  <= SEG_TS2;
              cnt_q  <= '0;
              lim2_q <= t2_x;
              used_q <= 1'b0;
            end else begin
              cnt_q <= pos1;
            end
          end
          SEG_TS2: begin
            lim2_q <= lim2_n;
            if (resync_w) used_q <= 1'b1;
            if (bit_end_o) begin
              seg_q <= SEG_SYNC;
              cnt_q <= '0;
            end else begin
              cnt_q <= pos1;
            end
          end
          default: seg_q <= SEG_SYNC;
        endcase
      end
    end
  end

  assert_sample_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_hit_o |=> !sample_hit_o);
  assert_ext_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_q <= sjw_x);
  assert_lim2_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_q == SEG_TS2) |-> (lim2_q <= t2_x));
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing #(
  parameter int PRESC_W     = 8,
  parameter int TSEG1_W     = 5,
  parameter int TSEG2_W     = 4,
  parameter int SJW_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_BITS   = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] brp_i,
  input  logic [TSEG1_W-1:0] tseg1_i,
  input  logic [TSEG2_W-1:0] tseg2_i,
  input  logic [SJW_W-1:0]   sjw_i,
  input  logic               loop_i,
  input  logic               rx_i,
  input  logic               tx_bit_i,
  output logic               tx_o,
  output logic               rx_bit_o,
  output logic               sample_o,
  output logic               tx_strobe_o,
  output logic               bit_err_o
);
  logic tick_w, rx_eff_w, fall_w, hit_w, bend_w, tx_q;

  can_bt_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .brp_i (brp_i),
    .tick_o(tick_w)
  );

  can_bt_rx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rx_i    (rx_i),
    .loop_i  (loop_i),
    .tx_q_i  (tx_q),
    .rx_eff_o(rx_eff_w),
    .fall_o  (fall_w)
  );

  can_bt_seq #(
    .TSEG1_W  (TSEG1_W),
    .TSEG2_W  (TSEG2_W),
    .SJW_W    (SJW_W),
    .IDLE_BITS(IDLE_BITS)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_w),
    .fall_i      (fall_w),
    .rx_eff_i    (rx_eff_w),
    .tseg1_i     (tseg1_i),
    .tseg2_i     (tseg2_i),
    .sjw_i       (sjw_i),
    .sample_hit_o(hit_w),
    .bit_end_o   (bend_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q        <= 1'b1;
      rx_bit_o    <= 1'b1;
      sample_o    <= 1'b0;
      tx_strobe_o <= 1'b0;
      bit_err_o   <= 1'b0;
    end else begin
      sample_o    <= hit_w;
      tx_strobe_o <= bend_w;
      bit_err_o   <= hit_w & (rx_eff_w != tx_q);
      if (hit_w)  rx_bit_o <= rx_eff_w;
      if (bend_w) tx_q <= tx_bit_i;
    end
  end

  // recessive forced onto the bus in loop mode
  assign tx_o = loop_i | tx_q;

  assert_tx_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tx_q) |-> tx_strobe_o);
  assert_err_with_sample_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_err_o |-> sample_o);
  assert_loop_no_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o && $past(loop_i)) |-> !bit_err_o);
endmodule

// File: tb/can_bit_timing_bench.sv
module can_bit_timing_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE_BITS  = 11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] brp = 8'd2;
  logic [4:0] tseg1 = 5'd5;
  logic [3:0] tseg2 = 4'd3;
  logic [2:0] sjw = 3'd2;
  logic       loop_en = 1'b0, rx = 1'b1, tx_bit = 1'b1;
  logic       tx_o, rx_bit_o, sample_o, tx_strobe_o, bit_err_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_bit_timing u_can_bit_timing (
    .clk_i(clk), .rst_ni(rst_n), .brp_i(brp), .tseg1_i(tseg1), .tseg2_i(tseg2),
    .sjw_i(sjw), .loop_i(loop_en), .rx_i(rx), .tx_bit_i(tx_bit), .tx_o(tx_o),
    .rx_bit_o(rx_bit_o), .sample_o(sample_o), .tx_strobe_o(tx_strobe_o),
    .bit_err_o(bit_err_o)
  );

  int    checks = 0, fails = 0, cyc = 0;
  string phase = "R10 reset";
  bit    done = 0;

  // behavioural reference: position inside the bit, effective segment lengths
  int m_presc, m_pos, m_t1e, m_t2e, m_rcnt;
  bit m_used, m_pend, m_idle, m_s1, m_s2, m_prev, m_txq;
  bit m_sample, m_rxbit, m_err, m_txs;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_presc = 0; m_pos = 0; m_t1e = 0; m_t2e = 0; m_rcnt = 0;
    m_used = 0; m_pend = 0; m_idle = 1; m_s1 = 1; m_s2 = 1; m_prev = 1; m_txq = 1;
    m_sample = 0; m_rxbit = 1; m_err = 0; m_txs = 0;
  endtask

  task automatic model_step();
    bit eff, fall, tick, ev, hit, bend;
    int t1, t2, sj, k, lo;
    t1 = int'(tseg1); t2 = int'(tseg2); sj = int'(sjw);
    eff  = loop_en ? m_txq : m_s2;
    fall = m_prev && !eff;
    tick = (m_presc >= int'(brp));
    ev   = m_pend || fall;
    hit  = 0; bend = 0;
    if (tick) begin
      m_pend = 0;
      if (ev && m_idle) begin
        m_pos = 1; m_t1e = t1; m_t2e = t2; m_used = 1;
      end else if (m_pos == 0) begin
        m_pos = 1; m_t1e = t1; m_t2e = t2;
      end else if (m_pos <= m_t1e) begin
        if (ev && !m_used) begin
          m_t1e = t1 + ((m_pos < sj) ? m_pos : sj);
          m_used = 1;
        end
        if (m_pos >= m_t1e) begin hit = 1; m_used = 0; end
        m_pos++;
      end else begin
        k = m_pos - m_t1e;
        if (ev && !m_used) begin
          lo = (t2 > sj) ? t2 - sj : 0;
          m_t2e = (k > lo) ? k : lo;
          m_used = 1;
        end
        if (k >= m_t2e) begin bend = 1; m_pos = 0; end
        else m_pos++;
      end
    end else if (fall) m_pend = 1;
    m_presc = tick ? 0 : m_presc + 1;
    if (hit) begin
      if (!eff) begin m_idle = 0; m_rcnt = 0; end
      else begin
        if (m_rcnt < IDLE_BITS) m_rcnt++;
        if (m_rcnt >= IDLE_BITS) m_idle = 1;
      end
    end
    m_sample = hit;
    if (hit) m_rxbit = eff;
    m_err = hit && (eff != m_txq);
    m_txs = bend;
    m_prev = eff;
    m_s2 = m_s1;
    m_s1 = rx;
    if (bend) m_txq = tx_bit;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) model_reset();
    else model_step();
  end

  always @(negedge clk) begin
    if (!done && rst_n) begin
      chk(phase, "tx_o", tx_o, loop_en ? 1 : int'(m_txq));
      chk(phase, "sample_o", sample_o, m_sample);
      chk(phase, "tx_strobe_o", tx_strobe_o, m_txs);
      chk(phase, "rx_bit_o", rx_bit_o, m_rxbit);
      chk(phase, "bit_err_o", bit_err_o, m_err);
    end
  end

  task automatic next_strobe(output int t);
    do @(negedge clk); while (!tx_strobe_o);
    t = cyc;
  endtask

  task automatic next_sample(output int t);
    do @(negedge clk); while (!sample_o);
    t = cyc;
  endtask

  task automatic sender(int period, int nbits);
    for (int i = 0; i < nbits; i++) begin
      rx = (i == 0) ? 1'b0 : 1'($urandom);
      repeat (period) @(negedge clk);
      #2;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    int t0, t1, ts, c;
    bit rec;
    repeat (3) @(negedge clk);
    chk("R10", "tx_o", tx_o, 1);
    chk("R10", "rx_bit_o", rx_bit_o, 1);
    chk("R10", "sample_o", sample_o, 0);
    chk("R10", "tx_strobe_o", tx_strobe_o, 0);
    chk("R10", "bit_err_o", bit_err_o, 0);
    #2 rst_n = 1'b1;

    phase = "R1 R3 idle timing";
    next_strobe(t0);
    next_strobe(t0);
    next_strobe(t1);
    chk("R1", "bit period", t1 - t0, 3 * (1 + 5 + 3));
    next_sample(ts);
    next_strobe(t1);
    chk("R3", "sample to strobe", t1 - ts, 3 * 3);

    phase = "R5 R4 hard sync";
    #2 brp = 8'd0;
    repeat (10) @(negedge clk);
    c = cyc;
    #2 rx = 1'b0;
    next_sample(ts);
    chk("R5", "hard sync sample cycle", ts, c + 3 + 5);
    chk("R4", "rx_bit_o after sync", rx_bit_o, 0);
    repeat (40) @(negedge clk);
    #2 rx = 1'b1;
    repeat (40) @(negedge clk);

    phase = "R6 slow sender";
    #2 brp = 8'd1;
    repeat (20) @(negedge clk);
    #2;
    sender(20, 40);
    phase = "R7 fast sender";
    sender(16, 40);

    phase = "R5 idle re-entry";
    rx = 1'b1;
    repeat (18 * 14) @(negedge clk);
    #2;
    sender(18, 12);

    phase = "R2 R4 R9 data path";
    rx = 1'b1;
    repeat (18 * 14) @(negedge clk);
    #2 tx_bit = 1'b0;
    next_strobe(t0);
    chk("R2", "tx_o after strobe", tx_o, 0);
    next_sample(ts);
    chk("R9", "bit_err_o on mismatch", bit_err_o, 1);
    chk("R4", "rx_bit_o recessive", rx_bit_o, 1);
    #2 tx_bit = 1'b1;
    next_strobe(t0);
    next_sample(ts);
    chk("R9", "bit_err_o on match", bit_err_o, 0);
    repeat (36) @(negedge clk);

    phase = "R8 loop";
    #2 loop_en = 1'b1;
    rec = tx_bit;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      chk("R8", "tx_o recessive", tx_o, 1);
      if (tx_strobe_o) rec = tx_bit;
      if (sample_o) begin
        chk("R8", "rx_bit_o looped", rx_bit_o, rec);
        chk("R8", "bit_err_o in loop", bit_err_o, 0);
      end
      #2 rx = 1'($urandom);
      if (i % 7 == 0) tx_bit = 1'($urandom);
    end

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule